// File: doc/BRIEF.md
# Return-to-zero three-level line bit recovery

This block turns a digitized three-level return-to-zero avionics line into a stream of received bits. Two comparator flags arrive from the analog front end: one flag is high when the line sits at the positive (ONE) level, the other is high at the negative (ZERO) level, and when both are low the line is at NULL. The block samples both flags sixteen times per nominal bit. For each level it keeps a short sample history, and from those histories it decides whether each pulse forms a legal bit.

Each legal pulse produces a one-cycle `bit_valid` strobe, with the bit value on `bit_value`. A long NULL idle produces a one-cycle `gap_start`, which marks the start of a new word. A malformed pulse produces a one-cycle `seq_error`. After an error no bits are reported until the next word gap, so a word that was cut short is dropped whole. The `rate_low` input sets the divider that paces the sampling, and so selects between the fast rate and the slow rate.

Top module: `rz_bit_recover`

## Requirements
- R1: A sample is taken once every `DIV_HI` clocks when `rate_low` is 0 and once every `DIV_LO` clocks when it is 1. All pulse and gap lengths below are counted in samples.
- R2: A run of at least `MIN_RUN` consecutive samples at one level, followed by a NULL sample, gives exactly one `bit_valid` pulse on that first NULL sample. `bit_value` is 1 for the ONE level (`line_one`) and 0 for the ZERO level (`line_zero`).
- R3: A pulse shorter than `MIN_RUN` samples that returns to NULL raises `seq_error` and gives no bit.
- R4: A level held for `OVS` consecutive samples without returning to NULL raises `seq_error` on the `OVS`-th sample. A pulse of `OVS`-1 samples is still a valid bit.
- R5: A sample with both flags high raises `seq_error`.
- R6: A sample that changes directly from one level to the other, with no NULL between, raises `seq_error`.
- R7: Each fault raises exactly one `seq_error`. After it, no further error and no bit is reported until the line has been sampled at NULL.
- R8: `GAP_BITS`*`OVS` consecutive NULL samples raise one `gap_start` pulse. A longer idle does not repeat it.
- R9: After reset and after any `seq_error`, bits are withheld until the next `gap_start`.
- R10: While reset is held, all outputs are 0. `bit_valid`, `gap_start` and `seq_error` are single-cycle pulses, and no two of them are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_one | input | 1 | Comparator flag: line at ONE level |
| line_zero | input | 1 | Comparator flag: line at ZERO level |
| rate_low | input | 1 | 1 selects the slow-rate sample divider |
| bit_valid | output | 1 | One-cycle strobe for an accepted bit |
| bit_value | output | 1 | Value of the accepted bit |
| gap_start | output | 1 | One-cycle strobe at a word gap |
| seq_error | output | 1 | One-cycle strobe for a malformed bit |

## Verification
The hardest situation to reach is the one where a fault must be followed by silence: legal-looking pulses that arrive after an error must give no bit until a gap has been seen. To reach it, the stimulus produces a runt pulse and then a perfectly formed pulse. It then supplies an idle long enough for a gap and expects a bit only after that gap. The stimulus holds every level for a whole number of sample periods, so the number of samples in each pulse is exact. This puts the minimum-run and maximum-run boundaries one sample apart. It also makes a pulse timed for the slow rate show up as an overlong error while the fast rate is selected.

// File: rtl/rz_bit_recover.sv
module rz_bit_recover #(
  parameter int OVS      = 16,
  parameter int MIN_RUN  = 3,
  parameter int GAP_BITS = 3,
  parameter int DIV_HI   = 62,
  parameter int DIV_LO   = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_one,
  input  logic line_zero,
  input  logic rate_low,
  output logic bit_valid,
  output logic bit_value,
  output logic gap_start,
  output logic seq_error
);
  localparam int GAP_LEN = GAP_BITS * OVS;
  localparam int MAX_RUN = OVS - 1;
  localparam int DW = $clog2(DIV_LO + 1);
  localparam int CW = $clog2(OVS + 1);
  localparam int NW = $clog2(GAP_LEN + 1);

  logic [DW-1:0] div_cnt;
  logic [MIN_RUN-1:0] ones_sr, zeros_sr;
  logic prev_null;
  logic [CW-1:0] run_cnt;
  logic [NW-1:0] null_cnt;
  logic hold, in_seq;

  wire [DW-1:0] div_max = rate_low ? DW'(DIV_LO - 1) : DW'(DIV_HI - 1);
  wire tick = div_cnt >= div_max;

  wire s_null = !line_one && !line_zero;
  wire s_bad  = line_one && line_zero;
  wire prev_one  = ones_sr[0] && !zeros_sr[0];
  wire prev_zero = zeros_sr[0] && !ones_sr[0];
  wire same_lvl  = !s_bad && ((line_one && prev_one) || (line_zero && prev_zero));
  wire swap      = !s_bad && ((line_one && prev_zero) || (line_zero && prev_one));
  wire pulse_end = s_null && !prev_null;
  wire runt      = prev_one ? !(&ones_sr) : !(&zeros_sr);
  wire too_long  = same_lvl && (run_cnt >= CW'(MAX_RUN));
  wire fault     = s_bad || swap || too_long || (pulse_end && runt);
  wire gap_hit   = s_null && (null_cnt == NW'(GAP_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_sr  <= '0;
      zeros_sr <= '0;
      prev_null <= 1'b1;
      run_cnt  <= '0;
      null_cnt <= '0;
    end else if (tick) begin
      ones_sr  <= {ones_sr[MIN_RUN-2:0], line_one};
      zeros_sr <= {zeros_sr[MIN_RUN-2:0], line_zero};
      prev_null <= s_null;
      if (s_null || s_bad)           run_cnt <= '0;
      else if (!same_lvl)            run_cnt <= CW'(1);
      else if (run_cnt != CW'(OVS))  run_cnt <= run_cnt + 1'b1;
      if (!s_null)                       null_cnt <= '0;
      else if (null_cnt != NW'(GAP_LEN)) null_cnt <= null_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_valid <= 1'b0;
      bit_value <= 1'b0;
      gap_start <= 1'b0;
      seq_error <= 1'b0;
      hold      <= 1'b0;
      in_seq    <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      gap_start <= 1'b0;
      seq_error <= 1'b0;
      if (tick) begin
        if (hold) begin
          if (s_null) hold <= 1'b0;
        end else if (fault) begin
          seq_error <= 1'b1;
          hold      <= !s_null;
          in_seq    <= 1'b0;
        end else if (pulse_end && in_seq) begin
          bit_valid <= 1'b1;
          bit_value <= prev_one;
        end
        if (gap_hit) begin
          gap_start <= 1'b1;
          in_seq    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rz_bit_recover_chk.sv
module rz_bit_recover_chk (
  input logic clk,
  input logic rst_n,
  input logic line_one,
  input logic line_zero,
  input logic bit_valid,
  input logic gap_start,
  input logic seq_error,
  input logic in_seq
);
  assert_outputs_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_valid, gap_start, seq_error}));
  assert_bit_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);
  assert_gap_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_start |=> !gap_start);
  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_error |=> !seq_error);
  assert_bit_at_null_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(!line_one && !line_zero));
  assert_gap_at_null_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_start |-> $past(!line_one && !line_zero));
  assert_bit_needs_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(in_seq));
  assert_err_drops_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_error |-> !in_seq);
endmodule

bind rz_bit_recover rz_bit_recover_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_one(line_one), .line_zero(line_zero),
  .bit_valid(bit_valid), .gap_start(gap_start), .seq_error(seq_error),
  .in_seq(in_seq)
);

// File: tb/sim_rz_bit_recover.sv
module sim_rz_bit_recover;
  localparam int DH = 4;
  localparam int DL = 12;
  localparam int C_BIT0 = 0, C_BIT1 = 1, C_GAP = 2, C_ERR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_one = 1'b0, line_zero = 1'b0, rate_low = 1'b0;
  logic bit_valid, bit_value, gap_start, seq_error;
  int total = 0, bad = 0, cur_div = DH;
  bit done = 1'b0;
  int exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  rz_bit_recover #(.OVS(16), .MIN_RUN(3), .GAP_BITS(3), .DIV_HI(DH), .DIV_LO(DL)) u0 (
    .clk(clk), .rst_n(rst_n), .line_one(line_one), .line_zero(line_zero),
    .rate_low(rate_low), .bit_valid(bit_valid), .bit_value(bit_value),
    .gap_start(gap_start), .seq_error(seq_error));

  function automatic string cname(int c);
    case (c)
      C_BIT0: return "BIT0";
      C_BIT1: return "BIT1";
      C_GAP:  return "GAP";
      default: return "ERR";
    endcase
  endfunction

  task automatic expect_ev(int c, string tag);
    exp_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  task automatic hold_line(bit o, bit z, int n);
    line_one = o;
    line_zero = z;
    repeat (n * cur_div) @(negedge clk);
  endtask

  task automatic pulse(bit o, bit z, int w, int rest);
    hold_line(o, z, w);
    hold_line(1'b0, 1'b0, rest);
  endtask

  task automatic observe(int c);
    total++;
    if (exp_q.size() == 0) begin
      bad++;
      $display("FAIL R10 unexpected event: actual=%s expected=none", cname(c));
    end else begin
      int e = exp_q.pop_front();
      string t = tag_q.pop_front();
      if (e != c) begin
        bad++;
        $display("FAIL %s event mismatch: actual=%s expected=%s", t, cname(c), cname(e));
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (seq_error) observe(C_ERR);
      if (gap_start) observe(C_GAP);
      if (bit_valid) observe(bit_value ? C_BIT1 : C_BIT0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    total++;
    if ({bit_valid, bit_value, gap_start, seq_error} != 4'b0) begin
      bad++;
      $display("FAIL R10 reset outputs: actual=%b expected=0000",
               {bit_valid, bit_value, gap_start, seq_error});
    end
    rst_n = 1'b1;

    expect_ev(C_GAP, "R8");            hold_line(0, 0, 60);
    expect_ev(C_BIT1, "R2");           pulse(1, 0, 8, 8);
    expect_ev(C_BIT0, "R2");           pulse(0, 1, 8, 8);
    expect_ev(C_BIT1, "R2_min_run");   pulse(1, 0, 3, 13);

    expect_ev(C_ERR, "R3");            pulse(1, 0, 2, 14);
    pulse(1, 0, 8, 8);                 // R9: withheld until gap
    expect_ev(C_GAP, "R9");            hold_line(0, 0, 50);
    expect_ev(C_BIT0, "R9");           pulse(0, 1, 8, 8);

    expect_ev(C_ERR, "R5");            pulse(1, 1, 2, 10);
    expect_ev(C_GAP, "R8");            hold_line(0, 0, 50);
    expect_ev(C_ERR, "R6");            hold_line(1, 0, 4);
    hold_line(0, 1, 4);                // R7: no second error during hold
    hold_line(0, 0, 10);

    expect_ev(C_GAP, "R8");            hold_line(0, 0, 50);
    expect_ev(C_BIT1, "R4_max_ok");    pulse(1, 0, 15, 10);
    expect_ev(C_ERR, "R4");            pulse(1, 0, 16, 10);

    expect_ev(C_GAP, "R8");            hold_line(0, 0, 50);
    expect_ev(C_ERR, "R1");            pulse(1, 0, 24, 10);

    rate_low = 1'b1;
    cur_div = DL;
    expect_ev(C_GAP, "R1");            hold_line(0, 0, 50);
    expect_ev(C_BIT1, "R1");           pulse(1, 0, 8, 8);
    expect_ev(C_BIT0, "R1");           pulse(0, 1, 8, 8);
    hold_line(0, 0, 20);

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R10 missing events: actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule